// File: doc/BRIEF.md
# Indirect Post-Increment Move Sequencer

This block carries out the two accumulator moves whose effective address is held in data memory rather than in a register. The operand byte names a memory cell; that cell holds a pointer. The load form brings the byte the pointer addresses into the accumulator. The store form places the accumulator at the addressed location. Either way, the pointer cell is then rewritten with its value plus one. A following instruction with the same operand therefore walks through consecutive bytes.

The core that owns instruction fetch hands over three things on a start strobe: the opcode byte, the operand byte and the current accumulator. The sequencer then drives a single-port synchronous byte memory with one cycle of read latency. It reads the pointer, reads or writes the data byte, and writes the incremented pointer back. Padding cycles follow so that every instruction lasts the same fixed time. A one-cycle done pulse closes each instruction. A load also presents the new accumulator value with a one-cycle write strobe.

Top module: `ipi_move_seq`

## Requirements
- R1: After a synchronous reset, done_o, busy_o, mem_we_o and acc_we_o are 0 and acc_o is 0x00.
- R2: Opcode 0x3E (load): acc_o takes the byte at address mem[operand], and acc_we_o pulses high for exactly one cycle, 4 clock edges after the start edge.
- R3: Opcode 0x3F (store): the accumulator value sampled with the start strobe is written to address mem[operand], and acc_we_o stays low.
- R4: In both forms, mem[operand] ends the instruction holding its old value plus one.
- R5: The pointer increment wraps from 0xFF to 0x00.
- R6: When mem[operand] equals operand, a store writes the accumulator first and the incremented pointer last, so that cell ends up holding operand+1.
- R7: If start is sampled at edge n, busy_o is high from edge n to edge n+10. done_o is high for exactly one cycle, after edge n+10, which is the 10th cycle.
- R8: A start strobe sampled while busy_o is high is ignored. It causes no extra memory write, no accumulator strobe and no extra done pulse.
- R9: A start strobe with any opcode other than 0x3E or 0x3F is ignored, and busy_o stays low.
- R10: mem_we_o is high 2 clock edges after the start edge for a store (data write) and 4 edges after it in both forms (pointer write-back). It is high in no other cycle, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction |
| opcode_i | input | 8 | Opcode byte, sampled with start_i |
| operand_i | input | 8 | Address of the pointer cell, sampled with start_i |
| acc_i | input | 8 | Current accumulator, sampled with start_i |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after the address |
| acc_o | output | 8 | New accumulator value |
| acc_we_o | output | 1 | One-cycle accumulator write strobe |
| done_o | output | 1 | One-cycle end-of-instruction pulse |
| busy_o | output | 1 | Instruction in progress |

## Verification
The hardest case to reach from the ports is a pointer that addresses its own cell. There the data access and the write-back hit the same byte, and only their order decides the final contents. The stimulus reaches it by preloading memory so that mem[operand] equals operand, for both the store and the load form. The pointer-wrap and busy-ignore cases are reached in a similar way: the memory is preloaded with a pointer of 0xFF, and a second start strobe is pulsed in the middle of a running instruction.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_LOAD  = 2'd1,
    FORM_STORE = 2'd2
  } form_e;

  // Counter value at which each step happens, counted from the start edge.
  localparam int PH_PTR  = 2;  // pointer byte arrives, issue data access
  localparam int PH_DATA = 4;  // load data arrives, issue write-back
endpackage

// File: rtl/ipi_op_decode.sv
module ipi_op_decode
  import ipi_pkg::*;
#(
  parameter int              OP_W     = 8,
  parameter logic [OP_W-1:0] OP_LOAD  = 8'h3E,
  parameter logic [OP_W-1:0] OP_STORE = 8'h3F
) (
  input  logic [OP_W-1:0] opcode_i,
  output form_e           form_o
);
  always_comb begin
    if (opcode_i == OP_LOAD)       form_o = FORM_LOAD;
    else if (opcode_i == OP_STORE) form_o = FORM_STORE;
    else                           form_o = FORM_NONE;
  end
endmodule

// File: rtl/ipi_seq_timer.sv
module ipi_seq_timer
  import ipi_pkg::*;
#(
  parameter int TOTAL_CYCLES = 10,
  localparam int CW = $clog2(TOTAL_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o,
  output logic ph_ptr_o,
  output logic ph_data_o,
  output logic ph_last_o
);
  localparam logic [CW-1:0] LAST   = CW'(TOTAL_CYCLES);
  localparam logic [CW-1:0] C_PTR  = CW'(PH_PTR);
  localparam logic [CW-1:0] C_DATA = CW'(PH_DATA);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (go_i)          cnt <= CW'(1);
    else if (cnt == LAST)   cnt <= '0;
    else if (cnt != '0)     cnt <= cnt + CW'(1);
  end

  assign busy_o    = (cnt != '0);
  assign ph_ptr_o  = (cnt == C_PTR);
  assign ph_data_o = (cnt == C_DATA);
  assign ph_last_o = (cnt == LAST);
endmodule

// File: rtl/ipi_move_seq.sv
module ipi_move_seq
  import ipi_pkg::*;
#(
  parameter int                WORD_W       = 8,
  parameter int                TOTAL_CYCLES = 10,
  parameter logic [WORD_W-1:0] OP_LOAD      = 8'h3E,
  parameter logic [WORD_W-1:0] OP_STORE     = 8'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] opcode_i,
  input  logic [WORD_W-1:0] operand_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] acc_o,
  output logic              acc_we_o,
  output logic              done_o,
  output logic              busy_o
);
  form_e             form;
  logic              go, ph_ptr, ph_data, ph_last;
  logic              is_store;
  logic [WORD_W-1:0] ptr_q, opnd_q, acc_q;

  ipi_op_decode #(.OP_W(WORD_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)) u_dec (
    .opcode_i (opcode_i),
    .form_o   (form)
  );

  assign go = start_i && !busy_o && (form != FORM_NONE);

  ipi_seq_timer #(.TOTAL_CYCLES(TOTAL_CYCLES)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .go_i      (go),
    .busy_o    (busy_o),
    .ph_ptr_o  (ph_ptr),
    .ph_data_o (ph_data),
    .ph_last_o (ph_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_o  <= '0;
      mem_we_o    <= 1'b0;
      mem_wdata_o <= '0;
      acc_o       <= '0;
      acc_we_o    <= 1'b0;
      done_o      <= 1'b0;
      ptr_q       <= '0;
      opnd_q      <= '0;
      acc_q       <= '0;
      is_store    <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      acc_we_o <= 1'b0;
      done_o   <= ph_last;
      if (go) begin
        opnd_q     <= operand_i;
        acc_q      <= acc_i;
        is_store   <= (form == FORM_STORE);
        mem_addr_o <= operand_i;          // fetch the pointer byte
      end
      if (ph_ptr) begin
        ptr_q      <= mem_rdata_i;
        mem_addr_o <= mem_rdata_i;        // data access at the pointer
        if (is_store) begin
          mem_we_o    <= 1'b1;
          mem_wdata_o <= acc_q;
        end
      end
      if (ph_data) begin
        if (!is_store) begin
          acc_o    <= mem_rdata_i;
          acc_we_o <= 1'b1;
        end
        mem_addr_o  <= opnd_q;            // write the pointer back last
        mem_we_o    <= 1'b1;
        mem_wdata_o <= ptr_q + WORD_W'(1);
      end
    end
  end
endmodule

// File: rtl/ipi_move_seq_chk.sv
module ipi_move_seq_chk #(
  parameter int                WORD_W   = 8,
  parameter logic [WORD_W-1:0] OP_LOAD  = 8'h3E,
  parameter logic [WORD_W-1:0] OP_STORE = 8'h3F
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [WORD_W-1:0] opcode_i,
  input logic              mem_we_o,
  input logic              acc_we_o,
  input logic              done_o,
  input logic              busy_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !done_o && !busy_o && !mem_we_o && !acc_we_o); // R1
  AST_ACC_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) acc_we_o |=> !acc_we_o); // R2
  AST_ACC_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst) acc_we_o |-> busy_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R7
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> $past(start_i)); // R8
  AST_OPCODE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(opcode_i) == OP_LOAD || $past(opcode_i) == OP_STORE)); // R9
  AST_WRITE_SPACED: assert property (@(posedge clk) disable iff (rst) mem_we_o |=> !mem_we_o); // R10
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst) mem_we_o |-> busy_o); // R10
endmodule

bind ipi_move_seq ipi_move_seq_chk #(.WORD_W(WORD_W), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)) u_chk (.*);

// File: tb/tb_ipi_move_seq.sv
module tb_ipi_move_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] opcode_i = 8'h00, operand_i = 8'h00, acc_i = 8'h00;
  logic [7:0] mem_addr_o, mem_wdata_o, acc_o;
  logic [7:0] mem_rdata_i = 8'h00;
  logic       mem_we_o, acc_we_o, done_o, busy_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ipi_move_seq dut (.*);

  // Synchronous single-port byte memory, one-cycle read latency.
  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
    mem_rdata_i <= mem[mem_addr_o];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Cycle model: cycles left in the running instruction.
  int m_left = 0;
  bit m_store = 0, m_done = 0;
  always @(posedge clk) begin
    m_done = 0;
    if (rst) m_left = 0;
    else if (m_left != 0) begin
      m_left--;
      if (m_left == 0) m_done = 1;
    end else if (start_i && (opcode_i == 8'h3E || opcode_i == 8'h3F)) begin
      m_left  = 10;
      m_store = (opcode_i == 8'h3F);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(done_o == m_done, "R7", "done_o", done_o, m_done);
      chk(busy_o == (m_left != 0), "R7/R8", "busy_o", busy_o, m_left != 0);
      chk(acc_we_o == (m_left == 6 && !m_store), "R2/R3", "acc_we_o",
          acc_we_o, (m_left == 6 && !m_store));
      chk(mem_we_o == ((m_left == 8 && m_store) || m_left == 6), "R10", "mem_we_o",
          mem_we_o, ((m_left == 8 && m_store) || m_left == 6));
    end
  end

  task automatic pulse_start(input logic [7:0] op, input logic [7:0] opnd,
                             input logic [7:0] acc);
    opcode_i = op; operand_i = opnd; acc_i = acc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done_o && k < 40) begin @(negedge clk); k++; end
    chk(done_o, "R7", "done reached", done_o, 1);
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] opnd,
                     input logic [7:0] acc, input string req);
    logic [7:0] p, expd, expp;
    p    = mem[opnd];
    expp = p + 8'd1;
    expd = (op == 8'h3F) ? acc : mem[p];
    pulse_start(op, opnd, acc);
    wait_done();
    if (op == 8'h3E) begin
      chk(acc_o == expd, req, "load acc_o", acc_o, expd);
    end else if (p != opnd) begin
      chk(mem[p] == expd, req, "stored byte", mem[p], expd);
    end
    chk(mem[opnd] == expp, req, "pointer write-back", mem[opnd], expp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is held
    chk(!done_o && !busy_o && !mem_we_o && !acc_we_o, "R1", "reset outputs",
        {done_o, busy_o, mem_we_o, acc_we_o}, 0);
    chk(acc_o == 8'h00, "R1", "reset acc_o", acc_o, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 / R4 plain load
    mem[8'h10] = 8'h80; mem[8'h80] = 8'h5A;
    run(8'h3E, 8'h10, 8'h00, "R2");
    // R2 / R4 post-increment walks to the next byte
    mem[8'h81] = 8'hC3;
    run(8'h3E, 8'h10, 8'h00, "R4");
    // R3 store, back-to-back with the previous done cycle
    mem[8'h11] = 8'h90;
    run(8'h3F, 8'h11, 8'h77, "R3");
    run(8'h3F, 8'h11, 8'h78, "R4");
    chk(mem[8'h90] == 8'h77, "R3", "earlier store kept", mem[8'h90], 8'h77);

    // R5 wrap from 0xFF
    mem[8'h20] = 8'hFF;
    run(8'h3F, 8'h20, 8'h3C, "R5");
    chk(mem[8'h20] == 8'h00, "R5", "wrapped pointer", mem[8'h20], 0);
    mem[8'h00] = 8'h99;
    run(8'h3E, 8'h20, 8'h00, "R5");

    // R6 pointer that names its own cell
    mem[8'h30] = 8'h30;
    run(8'h3F, 8'h30, 8'hEE, "R6");
    chk(mem[8'h30] == 8'h31, "R6", "write-back last", mem[8'h30], 8'h31);
    mem[8'h31] = 8'h31;
    run(8'h3E, 8'h31, 8'h00, "R6");
    chk(acc_o == 8'h31, "R6", "self-pointer load", acc_o, 8'h31);

    // R8 start during a running instruction is ignored
    mem[8'h40] = 8'hA0; mem[8'h50] = 8'h60; mem[8'h60] = 8'h11;
    pulse_start(8'h3F, 8'h40, 8'h22);
    @(negedge clk);
    pulse_start(8'h3E, 8'h50, 8'h00);
    wait_done();
    @(negedge clk);
    chk(mem[8'h50] == 8'h60, "R8", "ignored pointer untouched", mem[8'h50], 8'h60);
    chk(mem[8'hA0] == 8'h22, "R8", "running store done", mem[8'hA0], 8'h22);
    chk(!busy_o, "R8", "no second instruction", busy_o, 0);

    // R9 unknown opcodes ignored
    pulse_start(8'h3D, 8'h50, 8'h44);
    chk(!busy_o, "R9", "busy after 0x3D", busy_o, 0);
    pulse_start(8'h00, 8'h50, 8'h44);
    repeat (12) @(negedge clk);
    chk(mem[8'h50] == 8'h60, "R9", "memory untouched", mem[8'h50], 8'h60);
    chk(mem[8'h60] == 8'h11, "R9", "data untouched", mem[8'h60], 8'h11);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule